// File: doc/BRIEF.md
# Up/Down and Center-Aligned Timer Time-Base

This block is the counting core of a 16-bit PWM timer. Software sets it up through a small synchronous register port: a control word, a status word, the counter, the reload limit and a compare value. The counter can run in one direction, chosen by a direction bit, and wrap at either end. It can also run in one of three center-aligned modes, where it climbs from zero to the reload limit and falls back again, producing a symmetric triangle.

Each time the counter wraps or turns around, an update event occurs. The update event latches a flag and, when reload buffering is enabled, moves a pending reload value into the active limit. The compare channel flags a match between the counter and the compare value. In the center-aligned modes, the match counts only in the direction that the mode selects.

A free-running divider produces a strobe for downstream sampling logic, one cycle in 1, 2 or 4. Software can fold the update flag into bit 31 of a 32-bit counter read. This lets one access return both the count and whether a period boundary has passed.

Top module: `ctb_timer`

## Requirements
- R1: After reset every register reads 0, both interrupt outputs are low, and the sampling strobe is high on every cycle.
- R2: Control word at word address 0 has these fields. Bit 0 is run. Bit 1 is direction (1 = down). Bits 3:2 are the mode (00 single-direction, 01 center with compare on the down slope, 10 center with compare on the up slope, 11 center with compare on both slopes). Bit 4 is reload buffering. Bits 6:5 are the strobe divider. Bit 7 is flag-into-bit-31. Bits 15:8 read 0 and ignore writes.
- R3: In mode 00 with direction up, the counter increments each enabled cycle. On a cycle where it is at or above the active limit, it goes to 0 and raises an update event instead.
- R4: In mode 00 with direction down, the counter decrements each enabled cycle. On a cycle where it is at 0, it loads the active limit and raises an update event instead.
- R5: In a center mode, the counter behaves as follows. Counting up at or above a nonzero limit, it steps to value−1, turns to down and raises an update event. Counting down at 0, it steps to 1, turns to up and raises an update event. With a limit of 0, it stays at 0 and raises an update event every enabled cycle. In these modes, writes to the direction bit are ignored, and the bit reads the current slope.
- R6: On an enabled cycle where the counter equals the compare value (word address 4), the compare flag sets under these conditions. In mode 00 it always sets. In mode 01 it sets only while the current slope is down. In mode 10 it sets only while the slope is up. In mode 11 it sets on either slope. The slope is the direction state before that cycle's step.
- R7: With buffering off, a write to the reload limit (word address 3) becomes the active limit on the next cycle.
- R8: With buffering on, a reload write only updates the pending value that is read back. The active limit takes the pending value at the next update event.
- R9: The sampling strobe is high on one cycle in 1, 2 or 4 for divider codes 00, 01 and 10. Code 11 acts as 00. The strobe phase counts clock cycles since reset.
- R10: A 32-bit read of the counter (word address 2) returns the update flag in bit 31 when flag-into-bit-31 is set, and 0 there otherwise. A 16-bit read returns 0 in bits 31:16 for every register.
- R11: While run is 1 and the mode is 00, a control write that requests a center mode leaves the mode at 00. Leaving a center mode for 00 while running is accepted.
- R12: Status word (word address 1) holds the update flag in bit 0 and the compare flag in bit 1, and these drive irq_update and irq_compare. An event sets its flag. Writing 0 to a flag bit clears it, and writing 1 leaves it. When a set and a clear land on the same cycle, the set wins.
- R13: With run at 0, the counter and the direction state hold. A counter write loads the value on the next cycle, whether or not run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit read, 0 = 16-bit read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 16 | Write data (no writable bit lies above 15) |
| bus_rdata | output | 32 | Combinational read data |
| irq_update | output | 1 | Update flag |
| irq_compare | output | 1 | Compare flag |
| sample_en | output | 1 | Divided sampling strobe |

## Verification
The bench targets the turnaround cycles of the triangle, where a design that compares with the wrong slope flags the compare in the wrong mode. An off-by-one turnaround would show up as a counter that overshoots the limit or dwells twice at zero. With buffering on, the bench writes a new limit mid-period. A design that applies it early changes the period before the wrap, and one that never applies it keeps the old period. The mode-change lock is exercised both ways, as are the set-versus-clear race on the flags and bit 31 under 16- and 32-bit reads. A design that lets the direction bit be written in a center mode would break the triangle at once.

// File: rtl/ctb_pkg.sv
// Package: shared types and register map for the timer time-base.
// Assumes a word-addressed register port; widths below are fixed by the map.
package ctb_pkg;

    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_CDOWN = 2'b01,
        MODE_CUP   = 2'b10,
        MODE_CBOTH = 2'b11
    } cmode_t;

    typedef struct packed {
        logic       mirror;
        logic [1:0] div;
        logic       buffered;
        cmode_t     mode;
        logic       run;
    } ctrl_t;

    localparam int          ADDR_W  = 3;
    localparam int          RDATA_W = 32;
    localparam logic [2:0]  A_CTRL  = 3'd0;
    localparam logic [2:0]  A_STAT  = 3'd1;
    localparam logic [2:0]  A_CNT   = 3'd2;
    localparam logic [2:0]  A_RLD   = 3'd3;
    localparam logic [2:0]  A_CMP   = 3'd4;

endpackage

// File: rtl/ctb_div.sv
// Module: sampling strobe divider.
// Runs freely from reset; emits one strobe every 1, 2 or 4 cycles.
// Assumes the phase counter width covers the largest ratio.
module ctb_div #(
    parameter int PH_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       sample_en
);
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] mask;

    // Phase counter advances every clock since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + 1'b1;
    end

    // Pick the low bits that must be zero for a strobe; code 11 acts as 00.
    always_comb begin
        case (div_sel)
            2'b01:   mask = PH_W'(1);
            2'b10:   mask = PH_W'(3);
            default: mask = '0;
        endcase
    end

    assign sample_en = ((phase & mask) == '0);

    AST_DIV2_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b01 && sample_en) |=> (!sample_en || div_sel != 2'b01)); // R9

endmodule

// File: rtl/ctb_count.sv
// Module: counter and direction state.
// Handles single-direction wrap or reload and center-aligned turnaround.
// Raises an update event at each wrap or turn, and a slope-gated compare hit.
// Assumes the limit and compare inputs are already the active values.
module ctb_count
    import ctb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  cmode_t           mode,
    input  logic [CNT_W-1:0] top,
    input  logic [CNT_W-1:0] cmp,
    input  logic             dir_wr,
    input  logic             dir_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_down,
    output logic             upd_evt,
    output logic             cmp_hit
);
    logic [CNT_W-1:0] nxt_cnt;
    logic             nxt_dir;
    logic             center;
    logic             slope_ok;

    assign center = (mode != MODE_EDGE);

    // Next count, next slope and update event for an enabled cycle.
    always_comb begin
        nxt_cnt = cnt;
        nxt_dir = dir_down;
        upd_evt = 1'b0;
        if (run) begin
            if (!center) begin
                if (!dir_down) begin
                    if (cnt >= top) begin nxt_cnt = '0; upd_evt = 1'b1; end
                    else            nxt_cnt = cnt + 1'b1;
                end else begin
                    if (cnt == '0) begin nxt_cnt = top; upd_evt = 1'b1; end
                    else           nxt_cnt = cnt - 1'b1;
                end
            end else if (top == '0) begin
                nxt_cnt = '0;
                upd_evt = 1'b1;
            end else if (!dir_down) begin
                if (cnt >= top) begin
                    nxt_cnt = cnt - 1'b1; nxt_dir = 1'b1; upd_evt = 1'b1;
                end else nxt_cnt = cnt + 1'b1;
            end else begin
                if (cnt == '0) begin
                    nxt_cnt = CNT_W'(1); nxt_dir = 1'b0; upd_evt = 1'b1;
                end else nxt_cnt = cnt - 1'b1;
            end
        end
    end

    // Slope qualification of a compare match per mode.
    always_comb begin
        case (mode)
            MODE_CDOWN: slope_ok = dir_down;
            MODE_CUP:   slope_ok = !dir_down;
            default:    slope_ok = 1'b1;
        endcase
    end

    assign cmp_hit = run && (cnt == cmp) && slope_ok;

    // Counter register: a software write overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= cnt_wdata;
        else             cnt <= nxt_cnt;
    end

    // Direction register: software owns it only in single-direction mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                dir_down <= 1'b0;
        else if (dir_wr && !center) dir_down <= dir_wdata;
        else                       dir_down <= nxt_dir;
    end

    AST_EDGE_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !center && !dir_down && cnt >= top && !cnt_wr) |=> (cnt == '0)); // R3
    AST_CENTER_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && center && !dir_down && top != '0 && cnt >= top) |=> dir_down); // R5
    AST_FREEZE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt)); // R13

endmodule

// File: rtl/ctb_regs.sv
// Module: register file and read mux.
// Holds control, flags, pending and active limit, and compare value.
// Enforces the mode-change lock and set-over-clear on the flags.
// Assumes single-cycle synchronous writes and combinational reads.
module ctb_regs
    import ctb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]   cnt,
    input  logic               dir_down,
    input  logic               upd_evt,
    input  logic               cmp_hit,
    output ctrl_t              ctrl,
    output logic [CNT_W-1:0]   top_act,
    output logic [CNT_W-1:0]   cmp_val,
    output logic               dir_wr,
    output logic               dir_wdata,
    output logic               cnt_wr,
    output logic [CNT_W-1:0]   cnt_wdata,
    output logic               upd_flag,
    output logic               cmp_flag
);
    localparam int HALF_W = RDATA_W / 2;

    logic             wr_any, wr_ctrl, wr_stat, wr_rld, wr_cmp;
    logic [CNT_W-1:0] top_pend;
    cmode_t           req_mode;
    logic             mode_locked;
    logic [RDATA_W-1:0] rd_full;

    assign wr_any  = bus_sel && bus_wr;
    assign wr_ctrl = wr_any && (bus_addr == A_CTRL);
    assign wr_stat = wr_any && (bus_addr == A_STAT);
    assign cnt_wr  = wr_any && (bus_addr == A_CNT);
    assign wr_rld  = wr_any && (bus_addr == A_RLD);
    assign wr_cmp  = wr_any && (bus_addr == A_CMP);

    assign cnt_wdata = bus_wdata;
    assign dir_wr    = wr_ctrl;
    assign dir_wdata = bus_wdata[1];
    assign req_mode  = cmode_t'(bus_wdata[3:2]);
    assign mode_locked = ctrl.run && (ctrl.mode == MODE_EDGE) && (req_mode != MODE_EDGE);

    // Control fields; a locked mode request keeps the old mode.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl <= '0;
        else if (wr_ctrl) begin
            ctrl.run      <= bus_wdata[0];
            ctrl.buffered <= bus_wdata[4];
            ctrl.div      <= bus_wdata[6:5];
            ctrl.mirror   <= bus_wdata[7];
            if (!mode_locked) ctrl.mode <= req_mode;
        end
    end

    // Pending and active limit with optional buffering.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_pend <= '0;
            top_act  <= '0;
        end else begin
            if (upd_evt && ctrl.buffered) top_act <= top_pend;
            if (wr_rld) begin
                top_pend <= bus_wdata;
                if (!ctrl.buffered) top_act <= bus_wdata;
            end
        end
    end

    // Compare value, loaded directly.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_val <= '0;
        else if (wr_cmp) cmp_val <= bus_wdata;
    end

    // Flags: event sets, written zero clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            if (upd_evt)                      upd_flag <= 1'b1;
            else if (wr_stat && !bus_wdata[0]) upd_flag <= 1'b0;
            if (cmp_hit)                      cmp_flag <= 1'b1;
            else if (wr_stat && !bus_wdata[1]) cmp_flag <= 1'b0;
        end
    end

    // Read mux, then clip the upper half for narrow reads.
    always_comb begin
        rd_full = '0;
        case (bus_addr)
            A_CTRL: rd_full = RDATA_W'({ctrl.mirror, ctrl.div, ctrl.buffered,
                                        ctrl.mode, dir_down, ctrl.run});
            A_STAT: rd_full = RDATA_W'({cmp_flag, upd_flag});
            A_CNT:  rd_full = {ctrl.mirror && upd_flag, {(RDATA_W-1-CNT_W){1'b0}}, cnt};
            A_RLD:  rd_full = RDATA_W'(top_pend);
            A_CMP:  rd_full = RDATA_W'(cmp_val);
            default: rd_full = '0;
        endcase
        bus_rdata = bus_wide ? rd_full : {{HALF_W{1'b0}}, rd_full[HALF_W-1:0]};
    end

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl.run && ctrl.mode == MODE_EDGE && req_mode != MODE_EDGE)
        |=> (ctrl.mode == MODE_EDGE)); // R11
    AST_UPD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        upd_evt |=> upd_flag); // R12
    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.buffered && !upd_evt) |=> $stable(top_act)); // R8

endmodule

// File: rtl/ctb_timer.sv
// Module: timer time-base top.
// Joins the register file, the counter and the strobe divider.
// Assumes CNT_W is at most 31 so that bit 31 stays free for the flag.
module ctb_timer
    import ctb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [RDATA_W-1:0] bus_rdata,
    output logic               irq_update,
    output logic               irq_compare,
    output logic               sample_en
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] top_act, cmp_val, cnt, cnt_wdata;
    logic             dir_down, upd_evt, cmp_hit, dir_wr, dir_wdata, cnt_wr;

    ctb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cnt(cnt), .dir_down(dir_down),
        .upd_evt(upd_evt), .cmp_hit(cmp_hit), .ctrl(ctrl), .top_act(top_act),
        .cmp_val(cmp_val), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .upd_flag(irq_update),
        .cmp_flag(irq_compare)
    );

    ctb_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .mode(ctrl.mode),
        .top(top_act), .cmp(cmp_val), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt(cnt),
        .dir_down(dir_down), .upd_evt(upd_evt), .cmp_hit(cmp_hit)
    );

    ctb_div #(.PH_W(2)) u_div (
        .clk(clk), .rst_n(rst_n), .div_sel(ctrl.div), .sample_en(sample_en)
    );

endmodule

// File: tb/tb_ctb_timer.sv
// Bench: behavioural reference model stepped on every rising edge and
// compared with the outputs on every falling edge, plus tagged register reads.
module tb_ctb_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [31:0] bus_rdata;
    logic        irq_update, irq_compare, sample_en;

    int total = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ctb_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_update(irq_update),
        .irq_compare(irq_compare), .sample_en(sample_en)
    );

    // Reference model state
    logic [15:0] m_cnt, m_act, m_pre, m_cmp;
    logic        m_dir, m_run, m_buf, m_mir, m_uf, m_cf;
    logic [1:0]  m_mode, m_div;
    int          m_cyc;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mread(input logic [2:0] a, input logic w);
        logic [31:0] v;
        case (a)
            3'd0: v = {24'd0, m_mir, m_div, m_buf, m_mode, m_dir, m_run};
            3'd1: v = {30'd0, m_cf, m_uf};
            3'd2: v = {m_mir & m_uf, 15'd0, m_cnt};
            3'd3: v = {16'd0, m_pre};
            3'd4: v = {16'd0, m_cmp};
            default: v = 32'd0;
        endcase
        if (!w) v[31:16] = 16'd0;
        return v;
    endfunction

    // Model step, taken on the same edge that the design uses.
    always @(posedge clk) begin
        logic [15:0] ncnt, nact, npre, wd;
        logic ndir, ev, hit, gate, nuf, ncf, wr;
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_pre = 0; m_cmp = 0; m_dir = 0; m_run = 0;
            m_buf = 0; m_mir = 0; m_uf = 0; m_cf = 0; m_mode = 0; m_div = 0; m_cyc = 0;
        end else begin
            ev = 0; hit = 0; ncnt = m_cnt; ndir = m_dir;
            if (m_run) begin
                gate = (m_mode == 2'd1) ? m_dir : (m_mode == 2'd2) ? !m_dir : 1'b1;
                hit = (m_cnt == m_cmp) && gate;
                if (m_mode == 2'd0) begin
                    if (!m_dir) begin
                        if (m_cnt >= m_act) begin ncnt = 0; ev = 1; end else ncnt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin ncnt = m_act; ev = 1; end else ncnt = m_cnt - 1;
                    end
                end else if (m_act == 0) begin
                    ncnt = 0; ev = 1;
                end else if (!m_dir) begin
                    if (m_cnt >= m_act) begin ncnt = m_cnt - 1; ndir = 1; ev = 1; end
                    else ncnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin ncnt = 1; ndir = 0; ev = 1; end
                    else ncnt = m_cnt - 1;
                end
            end
            wr = bus_sel && bus_wr; wd = bus_wdata;
            nuf = m_uf; ncf = m_cf;
            if (wr && bus_addr == 3'd1) begin
                if (!wd[0]) nuf = 0;
                if (!wd[1]) ncf = 0;
            end
            if (ev) nuf = 1;
            if (hit) ncf = 1;
            nact = m_act; npre = m_pre;
            if (ev && m_buf) nact = m_pre;
            if (wr && bus_addr == 3'd3) begin npre = wd; if (!m_buf) nact = wd; end
            if (wr && bus_addr == 3'd4) m_cmp = wd;
            if (wr && bus_addr == 3'd2) ncnt = wd;
            if (wr && bus_addr == 3'd0) begin
                if (m_mode == 2'd0) ndir = wd[1];
                if (!(m_run && m_mode == 2'd0 && wd[3:2] != 2'd0)) m_mode = wd[3:2];
                m_run = wd[0]; m_buf = wd[4]; m_div = wd[6:5]; m_mir = wd[7];
            end
            m_cnt = ncnt; m_dir = ndir; m_uf = nuf; m_cf = ncf; m_act = nact; m_pre = npre;
            m_cyc++;
        end
    end

    // Per-cycle comparison of flags and strobe (R12, R9).
    always @(negedge clk) begin
        int per;
        if (rst_n && !done) begin
            per = (m_div == 2'd1) ? 2 : (m_div == 2'd2) ? 4 : 1;
            chk({30'd0, irq_compare, irq_update}, {30'd0, m_cf, m_uf}, "R12 flags");
            chk({31'd0, sample_en}, {31'd0, (m_cyc % per) == 0}, "R9 strobe");
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rreg(input logic [2:0] a, input logic w, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_wide = w;
        #1 chk(bus_rdata, mread(a, w), tag);
        bus_sel = 0;
    endtask

    task automatic watch_cnt(input int n, input string tag);
        for (int i = 0; i < n; i++) rreg(3'd2, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int a = 0; a < 5; a++) rreg(3'(a), 1'b1, "R1 reset read");
        chk({31'd0, sample_en}, 32'd1, "R1 strobe");

        // R2: reserved control bits and field readback
        wreg(3'd0, 16'hFF7E);
        rreg(3'd0, 1'b1, "R2 ctrl fields");
        wreg(3'd0, 16'h0000);
        wreg(3'd0, 16'h0000);
        rreg(3'd0, 1'b0, "R2 ctrl cleared");

        // R7: unbuffered reload, compare value
        wreg(3'd3, 16'd5);
        wreg(3'd4, 16'd3);
        rreg(3'd3, 1'b0, "R7 reload read");
        // R3: single-direction up
        wreg(3'd0, 16'h0001);
        watch_cnt(14, "R3 up count");
        wreg(3'd1, 16'h0000);
        // R4: single-direction down
        wreg(3'd0, 16'h0003);
        watch_cnt(14, "R4 down count");
        // R13: freeze and direct load
        wreg(3'd0, 16'h0002);
        watch_cnt(3, "R13 frozen");
        rreg(3'd0, 1'b0, "R13 dir held");
        wreg(3'd2, 16'd2);
        watch_cnt(2, "R13 count load");

        // R5, R6: the three center modes
        for (int md = 1; md < 4; md++) begin
            wreg(3'd0, 16'h0000);
            wreg(3'd2, 16'd0);
            wreg(3'd3, 16'd4);
            wreg(3'd4, 16'd2);
            wreg(3'd1, 16'h0000);
            wreg(3'd0, 16'(md << 2) | 16'h0003);
            for (int k = 0; k < 12; k++) begin
                rreg(3'd2, 1'b0, "R5 triangle");
                rreg(3'd0, 1'b0, "R5 slope readback");
                rreg(3'd1, 1'b0, "R6 gated compare");
                if (k % 4 == 3) wreg(3'd1, 16'h0000);
            end
        end
        // R5: limit zero in center mode
        wreg(3'd3, 16'd0);
        watch_cnt(3, "R5 zero limit");

        // R11: mode lock, then allowed exit
        wreg(3'd0, 16'h0000);
        wreg(3'd3, 16'd6);
        wreg(3'd0, 16'h0001);
        wreg(3'd0, 16'h0009);
        rreg(3'd0, 1'b0, "R11 locked mode");
        wreg(3'd0, 16'h0000);
        wreg(3'd0, 16'h0008);
        wreg(3'd0, 16'h0009);
        rreg(3'd0, 1'b0, "R11 center while stopped");
        wreg(3'd0, 16'h0001);
        rreg(3'd0, 1'b0, "R11 exit to edge");

        // R8: buffered reload applied at the next update
        wreg(3'd0, 16'h0000);
        wreg(3'd2, 16'd0);
        wreg(3'd3, 16'd5);
        wreg(3'd0, 16'h0011);
        watch_cnt(2, "R8 before write");
        wreg(3'd3, 16'd9);
        rreg(3'd3, 1'b0, "R8 pending read");
        watch_cnt(18, "R8 period change");

        // R10: flag in bit 31
        wreg(3'd0, 16'h0091);
        watch_cnt(4, "R8 tail");
        rreg(3'd2, 1'b1, "R10 wide with flag");
        rreg(3'd2, 1'b0, "R10 narrow");
        wreg(3'd1, 16'h0000);
        wreg(3'd0, 16'h0080);
        rreg(3'd2, 1'b1, "R10 wide after clear");

        // R12: writing ones keeps flags
        wreg(3'd3, 16'd1);
        wreg(3'd0, 16'h0001);
        wreg(3'd0, 16'h0000);
        wreg(3'd1, 16'h0003);
        rreg(3'd1, 1'b0, "R12 write one keeps");
        // R12: set beats clear
        wreg(3'd0, 16'h0001);
        for (int k = 0; k < 3; k++) begin
            wreg(3'd1, 16'h0000);
            rreg(3'd1, 1'b0, "R12 set over clear");
        end

        // R9: divider codes
        for (int dv = 1; dv < 4; dv++) begin
            wreg(3'd0, 16'(dv << 5));
            repeat (9) @(negedge clk);
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1: actual hung expected finished");
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule